// File: doc/BRIEF.md
# Multi-Mode Timer with Prescaler and Postscaler

This block is a timer core with a counter that can count up, or up and then down. Each count step is an enable pulse. The pulse comes either from the system clock or from edges on an external event line, which is synchronised first. Before the enable reaches the counter it passes a power-of-two prescaler, and a bypass bit can skip that prescaler. The counter runs in one of four modes: a free-running wrap, a restart on compare, a single-slope pulse-width waveform and a dual-slope pulse-width waveform. The two waveform modes drive a pulse-width output.

Each wrap or compare event feeds a postscaler. The postscaler raises a sticky interrupt flag once every N events, with N from 1 to 16. Software writes the mode word, the TOP limit and the compare value through a small write port. It reads the running count on a dedicated output. In the waveform modes, new TOP and compare values are held back until the next period boundary.

Top module: `mmtimer_top`

## Requirements
- R1: While `rst_n` is low, `count_o` is 0 and both `pwm_o` and `irq_o` are 0.
- R2: In wrap mode (mode code 0), the count rises by one per enable, wraps from the all-ones value to 0, and raises an event on that wrap.
- R3: In clear-on-compare mode (mode code 1), an enable that finds the count equal to the compare register (address 2) returns the count to 0 and raises an event. With compare value C, the count repeats every C+1 enables.
- R4: In single-slope mode (mode code 2), the count runs from 0 up to the TOP value (address 1) and then wraps to 0, raising an event on the wrap. `pwm_o` is high exactly while the count is below the compare value, so it is high from 0 and low from the compare match.
- R5: In dual-slope mode (mode code 3), the count climbs to TOP and then falls back to 0, raising an event when it turns around at 0. With TOP=0 the count stays at 0 and every enable is an event. `pwm_o` is high while the count is below the compare value, so it toggles at the compare match on both slopes.
- R6: In both waveform modes, TOP and compare writes take effect only at the period boundary. In single-slope mode that is the wrap to 0. In dual-slope mode it is the turnaround at 0. In the other modes they take effect at once.
- R7: With bypass clear, a prescale exponent e (control bits 8:5, values above 8 treated as 8) lets through one enable per 2^e source pulses. The first enable comes on the 2^e-th source pulse after the last mode write.
- R8: With the bypass bit set (control bit 4), every source pulse is an enable, whatever the exponent.
- R9: With the external source selected (control bit 2), the count advances once for each rising edge of `ext_evt`, or each falling edge when control bit 3 is set. The other edge and a steady level never advance it.
- R10: With postscale field P (control bits 12:9), `irq_o` is raised on every (P+1)-th event.
- R11: `irq_o` stays high until a write to address 3 with data bit 0 set. A write there with bit 0 clear leaves the flag unchanged. A new interrupt in the same cycle as the clear wins over the clear.
- R12: A write to address 0 loads the control word (mode in bits 1:0) and restarts the block. The count becomes 0, the count direction becomes up, the shadows load, and the prescaler and postscaler counts are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 control, 1 TOP, 2 compare, 3 interrupt clear |
| wr_data | input | DATA_W | Write data |
| ext_evt | input | 1 | External event line, asynchronous |
| count_o | output | CNT_W | Current count |
| pwm_o | output | 1 | Pulse-width waveform output |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
The bench builds the block with an 8-bit counter and the default prescaler limit of 8. This lets a full 256-enable wrap, and an exponent saturated at 8, run to completion in a few hundred cycles each. It sweeps every TOP value from 0 to 7 against every compare value from 0 to TOP+1 in both waveform modes, and every compare value from 0 to 15 in clear-on-compare mode. It computes the count, the waveform level and the interrupt flag from closed-form expressions in the enable index. Directed sequences cover external edges, shadow timing, restarts on a mode write and the interrupt clear.

// File: rtl/mmt_pkg.sv
`timescale 1ns/1ps
package mmt_pkg;

  typedef enum logic [1:0] {
    MD_WRAP   = 2'd0,
    MD_CLRCMP = 2'd1,
    MD_PWM_SS = 2'd2,
    MD_PWM_DS = 2'd3
  } mmt_mode_e;

  // control word, most significant field first
  typedef struct packed {
    logic [3:0] post_m1;
    logic [3:0] pre_exp;
    logic       pre_bypass;
    logic       ext_fall;
    logic       ext_src;
    mmt_mode_e  mode;
  } mmt_cfg_t;

  localparam int CFG_W = $bits(mmt_cfg_t);

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_TOP  = 3'd1;
  localparam logic [2:0] A_CMP  = 3'd2;
  localparam logic [2:0] A_ACK  = 3'd3;

  function automatic logic is_wave_mode(input mmt_mode_e m);
    return (m == MD_PWM_SS) || (m == MD_PWM_DS);
  endfunction

endpackage

// File: rtl/mmt_edge_sync.sv
`timescale 1ns/1ps
module mmt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic fall_sel,
  output logic pulse
);

  localparam int SH_W = STAGES + 1;

  logic [SH_W-1:0] sh;
  logic            synced;
  logic            prev;
  logic            rise_det;
  logic            fall_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SH_W-2:0], din};
  end

  assign synced   = sh[STAGES-1];
  assign prev     = sh[STAGES];
  assign rise_det = synced & ~prev;
  assign fall_det = ~synced & prev;
  assign pulse    = fall_sel ? fall_det : rise_det;

endmodule

// File: rtl/mmt_prescaler.sv
`timescale 1ns/1ps
module mmt_prescaler #(
  parameter int MAX_EXP = 8,
  parameter int EXP_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             src,
  input  logic             bypass,
  input  logic [EXP_W-1:0] exp_sel,
  output logic             tick
);

  localparam int PC_W = (MAX_EXP < 1) ? 1 : MAX_EXP;

  // low e bits set; exponents beyond PC_W saturate to all ones
  function automatic logic [PC_W-1:0] ratio_mask(input logic [EXP_W-1:0] e);
    logic [PC_W-1:0] m;
    m = '0;
    for (int i = 0; i < PC_W; i++) m[i] = (i < int'(e));
    return m;
  endfunction

  logic [PC_W-1:0] pcnt;
  logic [PC_W-1:0] mask;

  assign mask = ratio_mask(exp_sel);
  assign tick = bypass ? src : (src && ((pcnt & mask) == mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pcnt <= '0;
    else if (clr) pcnt <= '0;
    else if (src) pcnt <= pcnt + 1'b1;
  end

endmodule

// File: rtl/mmt_postscaler.sv
`timescale 1ns/1ps
module mmt_postscaler #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             evt,
  input  logic [DIV_W-1:0] ratio_m1,
  output logic             fire
);

  logic [DIV_W-1:0] ecnt;

  assign fire = evt && (ecnt >= ratio_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ecnt <= '0;
    else if (clr)  ecnt <= '0;
    else if (evt)  ecnt <= fire ? '0 : ecnt + 1'b1;
  end

endmodule

// File: rtl/mmt_core.sv
`timescale 1ns/1ps
module mmt_core
  import mmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  mmt_mode_e        mode,
  input  logic [CNT_W-1:0] top_live,
  input  logic [CNT_W-1:0] cmp_live,
  output logic [CNT_W-1:0] count,
  output logic             pwm,
  output logic             evt,
  output logic [CNT_W-1:0] top_sh,
  output logic [CNT_W-1:0] cmp_sh
);

  localparam logic [CNT_W-1:0] MAXV = '1;

  function automatic logic wave_level(input logic [CNT_W-1:0] c,
                                      input logic [CNT_W-1:0] k);
    return c < k;
  endfunction

  function automatic logic [CNT_W-1:0] restart_value(input logic [CNT_W-1:0] t);
    return (t == '0) ? '0 : {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  logic             up_q, up_n;
  logic [CNT_W-1:0] cnt_n;
  logic             load;
  logic [CNT_W-1:0] top_n, cmp_n;
  logic             pwm_q, pwm_n;

  always_comb begin
    cnt_n = count;
    up_n  = up_q;
    evt   = 1'b0;
    load  = !is_wave_mode(mode);
    if (tick) begin
      case (mode)
        MD_WRAP: begin
          cnt_n = count + 1'b1;
          evt   = (count == MAXV);
        end
        MD_CLRCMP: begin
          if (count == cmp_live) begin
            cnt_n = '0;
            evt   = 1'b1;
          end else begin
            cnt_n = count + 1'b1;
          end
        end
        MD_PWM_SS: begin
          if (count >= top_sh) begin
            cnt_n = '0;
            evt   = 1'b1;
            load  = 1'b1;
          end else begin
            cnt_n = count + 1'b1;
          end
        end
        MD_PWM_DS: begin
          if (up_q) begin
            if (count >= top_sh) begin
              if (top_sh == '0) begin
                cnt_n = '0;
                evt   = 1'b1;
                load  = 1'b1;
              end else begin
                up_n  = 1'b0;
                cnt_n = count - 1'b1;
              end
            end else begin
              cnt_n = count + 1'b1;
            end
          end else begin
            if (count == '0) begin
              up_n  = 1'b1;
              evt   = 1'b1;
              load  = 1'b1;
              cnt_n = restart_value(top_live);
            end else begin
              cnt_n = count - 1'b1;
            end
          end
        end
        default: cnt_n = count;
      endcase
    end
    if (clr) begin
      cnt_n = '0;
      up_n  = 1'b1;
      evt   = 1'b0;
      load  = 1'b1;
    end
    top_n = load ? top_live : top_sh;
    cmp_n = load ? cmp_live : cmp_sh;
    pwm_n = wave_level(cnt_n, cmp_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      up_q   <= 1'b1;
      top_sh <= '1;
      cmp_sh <= '0;
      pwm_q  <= 1'b0;
    end else begin
      count  <= cnt_n;
      up_q   <= up_n;
      top_sh <= top_n;
      cmp_sh <= cmp_n;
      pwm_q  <= pwm_n;
    end
  end

  assign pwm = pwm_q & is_wave_mode(mode);

endmodule

// File: rtl/mmtimer_top.sv
`timescale 1ns/1ps
module mmtimer_top
  import mmt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 16,
  parameter int MAX_EXP     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ext_evt,
  output logic [CNT_W-1:0]  count_o,
  output logic              pwm_o,
  output logic              irq_o
);

  // DATA_W must be at least CFG_W and at least CNT_W

  mmt_cfg_t         ctrl_q;
  logic [CNT_W-1:0] top_q;
  logic [CNT_W-1:0] cmp_q;
  logic             irq_q;

  logic             cfg_wr;
  logic             irq_clr;
  logic             ext_pulse;
  logic             tick_src;
  logic             core_tick;
  logic             core_evt;
  logic             post_fire;
  logic [CNT_W-1:0] top_sh;
  logic [CNT_W-1:0] cmp_sh;
  mmt_mode_e        mode_w;
  logic             pre_bypass;
  logic [3:0]       pre_exp;

  assign cfg_wr     = wr_en && (wr_addr == A_CTRL);
  assign irq_clr    = wr_en && (wr_addr == A_ACK) && wr_data[0];
  assign mode_w     = ctrl_q.mode;
  assign pre_bypass = ctrl_q.pre_bypass;
  assign pre_exp    = ctrl_q.pre_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      top_q  <= '1;
      cmp_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:  ctrl_q <= mmt_cfg_t'(wr_data[CFG_W-1:0]);
        A_TOP:   top_q  <= wr_data[CNT_W-1:0];
        A_CMP:   cmp_q  <= wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq_q <= 1'b0;
    else if (post_fire) irq_q <= 1'b1;
    else if (irq_clr)   irq_q <= 1'b0;
  end

  mmt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (ext_evt),
    .fall_sel (ctrl_q.ext_fall),
    .pulse    (ext_pulse)
  );

  assign tick_src = ctrl_q.ext_src ? ext_pulse : 1'b1;

  mmt_prescaler #(.MAX_EXP(MAX_EXP), .EXP_W(4)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cfg_wr),
    .src     (tick_src),
    .bypass  (pre_bypass),
    .exp_sel (pre_exp),
    .tick    (core_tick)
  );

  mmt_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cfg_wr),
    .tick     (core_tick),
    .mode     (mode_w),
    .top_live (top_q),
    .cmp_live (cmp_q),
    .count    (count_o),
    .pwm      (pwm_o),
    .evt      (core_evt),
    .top_sh   (top_sh),
    .cmp_sh   (cmp_sh)
  );

  mmt_postscaler #(.DIV_W(4)) u_post (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cfg_wr),
    .evt      (core_evt),
    .ratio_m1 (ctrl_q.post_m1),
    .fire     (post_fire)
  );

  assign irq_o = irq_q;

endmodule

// File: rtl/mmt_checker.sv
`timescale 1ns/1ps
module mmt_checker
  import mmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input mmt_mode_e        mode,
  input logic             tick,
  input logic             cfg_wr,
  input logic             irq_clr,
  input logic             post_fire,
  input logic             ext_pulse,
  input logic             pre_bypass,
  input logic [3:0]       pre_exp,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cmp_live,
  input logic [CNT_W-1:0] top_sh,
  input logic [CNT_W-1:0] cmp_sh,
  input logic             pwm,
  input logic             irq
);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_IDLE: assert (count == '0 && !pwm && !irq); // R1
    end
  end

  AST_WRAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && mode == MD_WRAP && !cfg_wr |=> count == CNT_W'($past(count) + 1'b1)); // R2

  AST_CLR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    tick && mode == MD_CLRCMP && count == cmp_live |=> count == '0); // R3

  AST_SS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    mode == MD_PWM_SS |-> count <= top_sh); // R4

  AST_DS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && mode == MD_PWM_DS && !cfg_wr |=>
      (count == CNT_W'($past(count) + 1'b1)) ||
      (count == CNT_W'($past(count) - 1'b1)) ||
      (count == '0 && $past(count) == '0)); // R5

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    is_wave_mode(mode) && !tick && !cfg_wr |=> $stable(top_sh) && $stable(cmp_sh)); // R6

  AST_PRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_bypass && pre_exp != 4'd0 && tick && !cfg_wr |=> !tick); // R7

  AST_EXT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_pulse && !cfg_wr |=> !ext_pulse); // R9

  AST_POST_SET: assert property (@(posedge clk) disable iff (!rst_n)
    post_fire |=> irq); // R10

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq); // R11

  AST_CFG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> count == '0); // R12

endmodule

bind mmtimer_top mmt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode_w),
  .tick       (core_tick),
  .cfg_wr     (cfg_wr),
  .irq_clr    (irq_clr),
  .post_fire  (post_fire),
  .ext_pulse  (ext_pulse),
  .pre_bypass (pre_bypass),
  .pre_exp    (pre_exp),
  .count      (count_o),
  .cmp_live   (cmp_q),
  .top_sh     (top_sh),
  .cmp_sh     (cmp_sh),
  .pwm        (pwm_o),
  .irq        (irq_o)
);

// File: tb/mmtimer_top_tb.sv
`timescale 1ns/1ps
module mmtimer_top_tb;

  localparam int CNT_W  = 8;
  localparam int DATA_W = 16;
  localparam int WRAPN  = 1 << CNT_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [2:0]        wr_addr = 3'd0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              ext_evt = 1'b0;
  logic [CNT_W-1:0]  count_o;
  logic              pwm_o;
  logic              irq_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  mmtimer_top #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ext_evt(ext_evt),
    .count_o(count_o), .pwm_o(pwm_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // caller sits just after a falling edge; returns after the capturing edge
  task automatic wr(input logic [2:0] a, input int d);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d[DATA_W-1:0];
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  function automatic int mkcfg(input int md, input int ext, input int fall,
                               input int byp, input int e, input int post);
    return (post << 9) | (e << 5) | (byp << 4) | (fall << 3) | (ext << 2) | md;
  endfunction

  function automatic int fds(input int j, input int t);
    int p;
    if (t == 0) return 0;
    p = j % (2 * t);
    return (p <= t) ? p : 2 * t - p;
  endfunction

  function automatic int exp_count(input int md, input int j, input int t, input int c);
    case (md)
      0:       return j % WRAPN;
      1:       return j % (c + 1);
      2:       return j % (t + 1);
      default: return fds(j, t);
    endcase
  endfunction

  function automatic int exp_events(input int md, input int j, input int t, input int c);
    case (md)
      0: return j / WRAPN;
      1: return j / (c + 1);
      2: return j / (t + 1);
      default: begin
        if (t == 0) return j;
        return (j >= 1) ? (j - 1) / (2 * t) : 0;
      end
    endcase
  endfunction

  task automatic sweep(input string ctag, input int md, input int t, input int c,
                       input int e, input int byp, input int post, input int kmax);
    int ec, j, ecnt, eirq, epwm;
    string ptag;
    ec   = (e > 8) ? 8 : e;
    ptag = (md == 3) ? "R5" : ((md == 2) ? "R4" : ctag);
    wr(3'd1, t);
    wr(3'd2, c);
    wr(3'd0, mkcfg(md, 0, 0, byp, e, post));
    chk("R12", "count after mode write", int'(count_o), 0);
    wr(3'd3, 1);
    for (int k = 1; k <= kmax; k++) begin
      if (k > 1) @(negedge clk);
      j    = (byp != 0) ? k : (k >> ec);
      ecnt = exp_count(md, j, t, c);
      epwm = (md >= 2) ? int'(ecnt < c) : 0;
      eirq = int'(exp_events(md, j, t, c) >= post + 1);
      chk(ctag, "count", int'(count_o), ecnt);
      chk(ptag, "pwm", int'(pwm_o), epwm);
      chk("R10", "irq", int'(irq_o), eirq);
    end
  endtask

  task automatic pulse_ext(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      ext_evt = 1'b1;
      repeat (hi) @(negedge clk);
      ext_evt = 1'b0;
      repeat (lo) @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : main
    int ecnt;
    repeat (3) @(negedge clk);
    chk("R1", "count in reset", int'(count_o), 0);
    chk("R1", "pwm in reset", int'(pwm_o), 0);
    chk("R1", "irq in reset", int'(irq_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 wrap mode, with and without postscale
    sweep("R2", 0, 255, 0, 0, 0, 0, 300);
    sweep("R10", 0, 255, 0, 0, 0, 1, 600);

    // R3 clear-on-compare, every compare value 0..15, varied postscale
    for (int c = 0; c < 16; c++) sweep("R3", 1, 255, c, 0, 0, c % 4, 50);
    sweep("R10", 1, 255, 0, 0, 0, 15, 40);

    // R4 / R5 waveform modes, TOP 0..7 against compare 0..TOP+1
    for (int t = 0; t < 8; t++)
      for (int c = 0; c <= t + 1; c++) sweep("R4", 2, t, c, 0, 0, 0, 40);
    for (int t = 0; t < 8; t++)
      for (int c = 0; c <= t + 1; c++) sweep("R5", 3, t, c, 0, 0, 0, 40);

    // R7 prescaler exponents, including saturation above 8
    for (int e = 1; e <= 4; e++) sweep("R7", 1, 255, 3, e, 0, 0, 120);
    sweep("R7", 0, 255, 0, 12, 0, 0, 600);

    // R8 bypass ignores exponent
    sweep("R8", 1, 255, 4, 5, 1, 0, 40);
    sweep("R8", 2, 7, 3, 8, 1, 0, 40);

    // R6 single-slope shadowing
    wr(3'd1, 9);
    wr(3'd2, 4);
    wr(3'd0, mkcfg(2, 0, 0, 0, 0, 0));
    repeat (3) @(negedge clk);
    chk("R6", "ss count before update", int'(count_o), 3);
    wr(3'd1, 5);
    wr(3'd2, 2);
    for (int k = 5; k <= 25; k++) begin
      if (k > 5) @(negedge clk);
      ecnt = (k <= 9) ? k : (k - 10) % 6;
      chk("R6", "ss count", int'(count_o), ecnt);
      chk("R6", "ss pwm", int'(pwm_o), (k <= 9) ? int'(k < 4) : int'(ecnt < 2));
    end

    // R6 dual-slope shadowing
    wr(3'd1, 4);
    wr(3'd2, 2);
    wr(3'd0, mkcfg(3, 0, 0, 0, 0, 0));
    @(negedge clk);
    wr(3'd1, 2);
    wr(3'd2, 1);
    for (int k = 3; k <= 30; k++) begin
      if (k > 3) @(negedge clk);
      ecnt = (k <= 8) ? fds(k, 4) : fds(k - 8, 2);
      chk("R6", "ds count", int'(count_o), ecnt);
      chk("R6", "ds pwm", int'(pwm_o), (k <= 8) ? int'(ecnt < 2) : int'(ecnt < 1));
    end

    // R9 external counting, rising edges
    wr(3'd0, mkcfg(0, 1, 0, 1, 0, 0));
    pulse_ext(10, 3, 3);
    repeat (6) @(negedge clk);
    chk("R9", "rising edges counted", int'(count_o), 10);
    ext_evt = 1'b1;
    repeat (20) @(negedge clk);
    chk("R9", "steady high", int'(count_o), 11);
    ext_evt = 1'b0;
    repeat (20) @(negedge clk);
    chk("R9", "falling ignored", int'(count_o), 11);
    wr(3'd0, mkcfg(0, 1, 1, 1, 0, 0));
    chk("R12", "restart on falling cfg", int'(count_o), 0);
    pulse_ext(7, 2, 2);
    repeat (6) @(negedge clk);
    chk("R9", "falling edges counted", int'(count_o), 7);
    wr(3'd0, mkcfg(0, 1, 0, 1, 0, 0));
    pulse_ext(8, 1, 1);
    repeat (6) @(negedge clk);
    chk("R9", "fast rising edges", int'(count_o), 8);
    wr(3'd0, mkcfg(0, 1, 0, 0, 1, 0));
    pulse_ext(10, 2, 2);
    repeat (6) @(negedge clk);
    chk("R7", "ext edges halved", int'(count_o), 5);

    // R12 postscaler restart
    wr(3'd2, 3);
    wr(3'd0, mkcfg(1, 0, 0, 0, 0, 2));
    wr(3'd3, 1);
    repeat (7) @(negedge clk);
    chk("R12", "irq before restart", int'(irq_o), 0);
    wr(3'd0, mkcfg(1, 0, 0, 0, 0, 2));
    chk("R12", "count after restart", int'(count_o), 0);
    repeat (8) @(negedge clk);
    chk("R12", "postscaler cleared", int'(irq_o), 0);
    repeat (4) @(negedge clk);
    chk("R12", "third event after restart", int'(irq_o), 1);

    // R12 prescaler restart
    wr(3'd0, mkcfg(0, 0, 0, 0, 3, 0));
    repeat (5) @(negedge clk);
    wr(3'd0, mkcfg(0, 0, 0, 0, 3, 0));
    repeat (7) @(negedge clk);
    chk("R12", "prescaler cleared", int'(count_o), 0);
    @(negedge clk);
    chk("R12", "first enable after restart", int'(count_o), 1);

    // R11 sticky flag and clear
    chk("R11", "irq still set", int'(irq_o), 1);
    wr(3'd3, 2);
    chk("R11", "clear with bit0 low", int'(irq_o), 1);
    wr(3'd3, 1);
    chk("R11", "clear with bit0 high", int'(irq_o), 0);
    repeat (5) @(negedge clk);
    chk("R11", "stays clear", int'(irq_o), 0);
    wr(3'd2, 0);
    wr(3'd0, mkcfg(1, 0, 0, 0, 0, 0));
    wr(3'd3, 1);
    chk("R11", "set wins over clear", int'(irq_o), 1);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule